// File: doc/BRIEF.md
# Dual-Channel Memory Bandwidth Monitor

This block watches the traffic of two independent memory channels and turns it into a utilisation figure for each one. Every channel supplies three per-cycle event strobes: a write beat, a read beat and a row activation. While monitoring is on, each channel keeps four saturating counters: write beats, read beats, row activations and elapsed window cycles.

A short control handshake drives the block. `run_start` clears the counters and starts counting. `run_stop` freezes them. `sample_req` freezes them and computes, for each channel, the truncated integer `((writes + reads) * 400) / cycles`. The product is formed at a wide internal precision, so it cannot overflow. One restoring divider serves both channels in turn. When both quotients are ready, the pair is presented together with a single-cycle `result_valid` pulse.

If the block was monitoring when the sample was requested, it clears its counters and resumes on its own. Each window is therefore measured independently. If it was stopped, the counters keep their contents.

Top module: `bwmon_top`

## Requirements
- R1: For each channel the reported value is floor((write beats + read beats) * 400 / window cycles). A window cycle is any clock cycle in which monitoring is active. A cycle that carries `run_start`, `run_stop` or `sample_req` is not counted, and neither are its strobes.
- R2: The product is formed at PROD_W bits (default 64) before the division. With every counter saturated, the result is still exact, and no reported value exceeds 800.
- R3: Row-activation strobes are counted but have no effect on either reported value.
- R4: From a `sample_req` until its result appears, event strobes are not counted.
- R5: A sample taken while monitoring clears all eight counters in the cycle in which the result appears. Counting resumes from that cycle, so the next window does not depend on the previous one.
- R6: `run_start` clears all counters and starts monitoring. `run_stop` freezes the counters without clearing them. Strobes while stopped are not counted, and a sample taken while stopped leaves the counters intact, so repeated samples give the same pair.
- R7: A channel whose window cycle count is zero reports 0.
- R8: Both channel values are updated together. `result_valid` is high for exactly one cycle per accepted sample, and the two channels never influence each other.
- R9: Every counter saturates at 2^CNT_W-1 instead of wrapping.
- R10: A `sample_req` that arrives while a computation is in progress is ignored and produces no extra result.
- R11: After reset, `result_valid` and both values are 0, monitoring is stopped and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Clear counters and begin monitoring |
| run_stop | input | 1 | Freeze counters and stop monitoring |
| sample_req | input | 1 | Freeze counters and compute both values |
| wr_beat | input | 2 | Write-beat strobe, bit n for channel n |
| rd_beat | input | 2 | Read-beat strobe, bit n for channel n |
| row_act | input | 2 | Row-activation strobe, bit n for channel n |
| result_valid | output | 1 | One-cycle pulse when both values are updated |
| eff_ch0 | output | EFF_W | Utilisation value of channel 0 |
| eff_ch1 | output | EFF_W | Utilisation value of channel 1 |

## Verification
The channels are driven with different read and write periods, so a swapped channel or a swapped read/write count shows up as a wrong value. A window with both strobes active every cycle checks the 800 ceiling. A window with activations active every cycle, plus strobes kept active during the computation, separates correct freezing from leakage into the result. A stop-then-sample sequence, repeated twice, tells freezing apart from clearing. An immediate sample checks the zero-cycle case. A window longer than the counter range, with strobes that end early, gives different values depending on whether the counters saturate or wrap.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;
  localparam int NUM_CH    = 2;
  localparam int NUM_CNT   = 4;
  localparam int IDX_WR    = 0;
  localparam int IDX_RD    = 1;
  localparam int IDX_ACT   = 2;
  localparam int IDX_TIME  = 3;
  localparam int EFF_SCALE = 400;
  localparam int EFF_MAX   = 2 * EFF_SCALE;

  typedef enum logic [1:0] {
    MON_STOP = 2'd0,
    MON_RUN  = 2'd1,
    MON_DIV0 = 2'd2,
    MON_DIV1 = 2'd3
  } mon_state_e;
endpackage

// File: rtl/bwmon_sat_counter.sv
module bwmon_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // R9: a full counter holds its value until cleared
  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/bwmon_channel.sv
module bwmon_channel
  import bwmon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clr,
  input  logic                            en,
  input  logic                            wr,
  input  logic                            rd,
  input  logic                            act,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   cnt
);
  logic [NUM_CNT-1:0] inc;

  always_comb begin
    inc           = '0;
    inc[IDX_WR]   = en & wr;
    inc[IDX_RD]   = en & rd;
    inc[IDX_ACT]  = en & act;
    inc[IDX_TIME] = en;
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    bwmon_sat_counter #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (clr),
      .inc (inc[k]),
      .cnt (cnt[k])
    );
  end

  // R4 / R6: counters frozen whenever counting is disabled
  a_r4_freeze: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt));
  // R5: a clear empties every counter of the channel
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/bwmon_divider.sv
module bwmon_divider #(
  parameter int DVD_W = 64,
  parameter int DVS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);
  localparam int IT_W = $clog2(DVD_W + 1);

  logic             busy;
  logic [IT_W-1:0]  left;
  logic [DVS_W-1:0] dvs;
  logic [DVS_W-1:0] rem;
  logic [DVD_W-1:0] quo;
  logic [DVS_W:0]   trial;
  logic [DVS_W:0]   diff;
  logic             fits;

  always_comb begin
    trial = {rem, quo[DVD_W-1]};
    diff  = trial - {1'b0, dvs};
    fits  = (trial >= {1'b0, dvs});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
      dvs  <= '0;
      rem  <= '0;
      quo  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (divisor == '0) begin
            quo  <= '0;
            done <= 1'b1;
          end else begin
            busy <= 1'b1;
            left <= IT_W'(DVD_W);
            dvs  <= divisor;
            rem  <= '0;
            quo  <= dividend;
          end
        end
      end else begin
        rem  <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
        quo  <= {quo[DVD_W-2:0], fits};
        left <= left - 1'b1;
        if (left == IT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo;

  // R1: the partial remainder always stays below the divisor
  a_r1_rem_below: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rem < dvs));
  // R7: a zero divisor finishes at once with a zero quotient
  a_r7_zero_div: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor == '0) |=> (done && quotient == '0));
endmodule

// File: rtl/bwmon_top.sv
module bwmon_top
  import bwmon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PROD_W = 64,
  parameter int EFF_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_start,
  input  logic             run_stop,
  input  logic             sample_req,
  input  logic [1:0]       wr_beat,
  input  logic [1:0]       rd_beat,
  input  logic [1:0]       row_act,
  output logic             result_valid,
  output logic [EFF_W-1:0] eff_ch0,
  output logic [EFF_W-1:0] eff_ch1
);
  mon_state_e state;
  logic       resume;
  logic       sel;
  logic       div_go;
  logic       div_done;
  logic [PROD_W-1:0] div_q;
  logic [EFF_W-1:0]  q_hold;

  logic idle_like;
  logic accept_start;
  logic accept_sample;
  logic count_en;
  logic restart;
  logic cnt_clr;

  logic [NUM_CH-1:0][NUM_CNT-1:0][CNT_W-1:0] cnt_all;
  logic [PROD_W-1:0] beat_sum;
  logic [PROD_W-1:0] scaled;
  logic [CNT_W-1:0]  window;

  always_comb begin
    idle_like     = (state == MON_STOP) || (state == MON_RUN);
    accept_start  = idle_like && run_start;
    accept_sample = idle_like && sample_req && !run_start;
    count_en      = (state == MON_RUN) && !run_start && !run_stop && !sample_req;
    restart       = (state == MON_DIV1) && div_done && resume;
    cnt_clr       = accept_start || restart;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bwmon_channel #(.CNT_W(CNT_W)) u_ch (
      .clk (clk),
      .rst (rst),
      .clr (cnt_clr),
      .en  (count_en),
      .wr  (wr_beat[c]),
      .rd  (rd_beat[c]),
      .act (row_act[c]),
      .cnt (cnt_all[c])
    );
  end

  always_comb begin
    beat_sum = PROD_W'(cnt_all[sel][IDX_WR]) + PROD_W'(cnt_all[sel][IDX_RD]);
    scaled   = beat_sum * PROD_W'(EFF_SCALE);
    window   = cnt_all[sel][IDX_TIME];
  end

  bwmon_divider #(.DVD_W(PROD_W), .DVS_W(CNT_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_go),
    .dividend (scaled),
    .divisor  (window),
    .done     (div_done),
    .quotient (div_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= MON_STOP;
      resume       <= 1'b0;
      sel          <= 1'b0;
      div_go       <= 1'b0;
      q_hold       <= '0;
      result_valid <= 1'b0;
      eff_ch0      <= '0;
      eff_ch1      <= '0;
    end else begin
      div_go       <= 1'b0;
      result_valid <= 1'b0;
      case (state)
        MON_STOP, MON_RUN: begin
          if (accept_start) begin
            state <= MON_RUN;
          end else if (accept_sample) begin
            resume <= (state == MON_RUN);
            sel    <= 1'b0;
            div_go <= 1'b1;
            state  <= MON_DIV0;
          end else if (run_stop) begin
            state <= MON_STOP;
          end
        end
        MON_DIV0: begin
          if (div_done) begin
            q_hold <= div_q[EFF_W-1:0];
            sel    <= 1'b1;
            div_go <= 1'b1;
            state  <= MON_DIV1;
          end
        end
        default: begin
          if (div_done) begin
            result_valid <= 1'b1;
            eff_ch0      <= q_hold;
            eff_ch1      <= div_q[EFF_W-1:0];
            state        <= resume ? MON_RUN : MON_STOP;
          end
        end
      endcase
    end
  end

  // R8: one pulse per sample
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);
  // R2: wide product keeps every result within the physical ceiling
  a_r2_bound: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (eff_ch0 <= EFF_W'(EFF_MAX) && eff_ch1 <= EFF_W'(EFF_MAX)));
  // R10: a request during computation does not leave the divide states
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (state == MON_DIV0 && !div_done) |=> (state == MON_DIV0));
endmodule

// File: tb/bwmon_top_bench.sv
`timescale 1ns/1ps
module bwmon_top_bench;
  localparam int CNT_W = 8;
  localparam int EFF_W = 16;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_start = 1'b0, run_stop = 1'b0, sample_req = 1'b0;
  logic [1:0] wr_beat = '0, rd_beat = '0, row_act = '0;
  logic result_valid;
  logic [EFF_W-1:0] eff_ch0, eff_ch1;

  int checks = 0;
  int failures = 0;
  int results_seen = 0;
  int samples_sent = 0;
  bit finished = 0;

  int    exp0_q[$];
  int    exp1_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  bwmon_top #(.CNT_W(CNT_W), .PROD_W(64), .EFF_W(EFF_W)) u_bwmon_top (
    .clk, .rst, .run_start, .run_stop, .sample_req,
    .wr_beat, .rd_beat, .row_act,
    .result_valid, .eff_ch0, .eff_ch1
  );

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every result
  always @(negedge clk) begin
    if (!rst && result_valid) begin
      results_seen++;
      if (exp0_q.size() == 0) begin
        check("R10 unexpected result", 1, 0);
      end else begin
        automatic int e0 = exp0_q.pop_front();
        automatic int e1 = exp1_q.pop_front();
        automatic string t = tag_q.pop_front();
        check({t, " ch0"}, int'(eff_ch0), e0);
        check({t, " ch1"}, int'(eff_ch1), e1);
      end
    end
  end

  // window counts accumulated by the driver
  int w0, r0, w1, r1, ncyc;

  function automatic bit hit(int period, int i, int lim);
    return (period > 0) && (i < lim) && (i % period == 0);
  endfunction

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic int eff(int w, int r, int t);
    longint num;
    if (sat(t) == 0) return 0;
    num = (longint'(sat(w)) + longint'(sat(r))) * 400;
    return int'(num / longint'(sat(t)));
  endfunction

  task automatic clear_counts();
    w0 = 0; r0 = 0; w1 = 0; r1 = 0; ncyc = 0;
  endtask

  task automatic launch();
    run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
    clear_counts();
  endtask

  task automatic window(int n, int lim, int pw0, int pr0, int pw1, int pr1, bit act_on);
    for (int i = 0; i < n; i++) begin
      wr_beat[0] = hit(pw0, i, lim);
      rd_beat[0] = hit(pr0, i, lim);
      wr_beat[1] = hit(pw1, i, lim);
      rd_beat[1] = hit(pr1, i, lim);
      row_act    = act_on ? 2'b11 : 2'b00;
      w0 += int'(wr_beat[0]); r0 += int'(rd_beat[0]);
      w1 += int'(wr_beat[1]); r1 += int'(rd_beat[1]);
      ncyc++;
      @(negedge clk);
    end
    wr_beat = '0; rd_beat = '0; row_act = '0;
  endtask

  task automatic stop_and_junk(int k);
    run_stop = 1'b1;
    @(negedge clk);
    run_stop = 1'b0;
    for (int i = 0; i < k; i++) begin
      wr_beat = 2'b11; rd_beat = 2'b11; row_act = 2'b11;
      @(negedge clk);
    end
    wr_beat = '0; rd_beat = '0; row_act = '0;
  endtask

  // issue a sample, push expectation, wait for the result negedge
  task automatic sample(string tag, bit junk, bit extra_req, bit clear_after);
    sample_req = 1'b1;
    exp0_q.push_back(eff(w0, r0, ncyc));
    exp1_q.push_back(eff(w1, r1, ncyc));
    tag_q.push_back(tag);
    samples_sent++;
    @(negedge clk);
    sample_req = 1'b0;
    for (int i = 0; !result_valid; i++) begin
      if (junk) begin
        wr_beat = 2'b11; rd_beat = 2'b11; row_act = 2'b11;
      end
      sample_req = extra_req && (i == 3);
      @(negedge clk);
    end
    sample_req = 1'b0;
    wr_beat = '0; rd_beat = '0; row_act = '0;
    if (clear_after) clear_counts();
  endtask

  initial begin
    clear_counts();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check("R11 result_valid after reset", int'(result_valid), 0);
    check("R11 eff_ch0 after reset", int'(eff_ch0), 0);
    check("R11 eff_ch1 after reset", int'(eff_ch1), 0);

    // R11 / R7: sample from reset, counters zero
    sample("R11 R7 sample from reset", 1'b0, 1'b0, 1'b0);

    // R1 / R8: differing periods per channel
    launch();
    window(100, 100, 2, 3, 5, 0, 1'b0);
    sample("R1 R8 mixed periods", 1'b0, 1'b0, 1'b1);

    // R3 / R4 / R5: resumed window, activations on, strobes during compute
    window(37, 37, 1, 1, 0, 7, 1'b1);
    sample("R3 R4 R5 full load with activations", 1'b1, 1'b0, 1'b1);

    // R5 / R10: idle window after restart, extra request while busy
    window(60, 60, 0, 0, 0, 0, 1'b0);
    sample("R5 R10 idle window", 1'b0, 1'b1, 1'b1);

    // R6: stop freezes, strobes while stopped ignored, repeat sample holds
    window(90, 90, 3, 0, 1, 2, 1'b0);
    stop_and_junk(20);
    sample("R6 stopped sample", 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    sample("R6 repeat stopped sample", 1'b1, 1'b0, 1'b0);

    // R7: zero-length window
    launch();
    sample("R7 zero window", 1'b0, 1'b0, 1'b1);

    // R9 / R2: window longer than counter range, strobes end early
    window(400, 300, 1, 0, 0, 2, 1'b0);
    sample("R9 R2 saturation", 1'b0, 1'b0, 1'b1);

    repeat (10) @(negedge clk);
    // R10: exactly one result per accepted sample
    check("R10 result count", results_seen, samples_sent);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule